// File: doc/BRIEF.md
# Byte Program Retry Controller

This block writes a buffer of bytes into a parallel NOR-style flash through its command bus, one byte at a time. For every byte it sends the program set-up command, then a write carrying the target address and the data byte. It waits out a fixed program pulse and then issues the verify command. After a settling delay it reads the byte back and compares it with the source byte. When the read-back differs, the byte gets another pulse. The number of pulses per byte is capped.

A run begins with a one-cycle start strobe that carries a base address and a byte count. The block fetches each byte from a data source port by index. It returns the flash to read mode with a final 00h command, then raises a done flag, and raises a fail flag as well if any byte ran out of attempts. The bus strobe shape is set in clock cycles. The microsecond delays come from a prescaler parameter. Voltage switching and erasure are handled elsewhere.

Top module: `pgm_retry_seq`

## Requirements
- R1: After reset, chip enable, output enable and write enable are all high (inactive), and done and fail are low.
- R2: Each program attempt for the byte at index i writes 40h and then writes the source byte, both at address base+i. Every bus cycle of a run drives address base+i of the byte being handled.
- R3: A write cycle holds chip enable low for SETUP_CYC cycles with write enable high, then STROBE_CYC cycles with write enable low, then HOLD_CYC cycles with write enable high. A read cycle holds chip enable and output enable low for the same total with write enable high. Exactly one idle cycle separates back-to-back bus cycles.
- R4: After the data write, the bus stays idle for PULSE_US*CLK_PER_US+2 cycles, and then C0h is written.
- R5: After C0h, the bus stays idle for VERIFY_US*CLK_PER_US+2 cycles, and then one read cycle samples the flash data on its last cycle and compares it with the source byte.
- R6: On a match, the block moves to the next index and the attempt count restarts, so each byte gets up to MAX_TRIES pulses of its own.
- R7: On a mismatch with fewer than MAX_TRIES attempts made for that byte, the attempt repeats from the 40h write.
- R8: A mismatch on attempt MAX_TRIES stops the run. The block writes 00h, and done and fail both go high.
- R9: After the last byte matches, the block writes 00h at the last byte's address, done goes high and fail stays low. Done is visible in the cycle after that write ends.
- R10: Done and fail hold their values until a start in idle. That start clears both in the next cycle, and the first bus cycle begins one cycle later.
- R11: A start strobe during a run has no effect on the bus sequence or the flags.
- R12: A run with a byte count of zero performs only the 00h write and then ends with done high and fail low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle run request, taken only when idle |
| base_addr_i | input | AW | Flash address of the first byte |
| len_i | input | LW | Number of bytes to program |
| src_idx_o | output | LW | Index of the byte requested from the source |
| src_data_i | input | 8 | Source byte at src_idx_o, same cycle |
| fl_addr_o | output | AW | Flash address bus |
| fl_wdata_o | output | 8 | Flash write data bus |
| fl_rdata_i | input | 8 | Flash read data bus |
| fl_ce_n_o | output | 1 | Flash chip enable, active low |
| fl_oe_n_o | output | 1 | Flash output enable, active low |
| fl_we_n_o | output | 1 | Flash write enable, active low |
| done_o | output | 1 | Run finished (sticky) |
| fail_o | output | 1 | Run finished with a byte out of attempts (sticky) |

## Verification
The bench builds the block with an 8-bit address, a 4-bit length and three clocks per microsecond. This keeps the 10 µs pulse and the 6 µs settle down to a few dozen cycles each while leaving their real microsecond counts unchanged. MAX_TRIES is lowered to 4, so an attempt cap can be hit on a byte that needs nine pulses. Bytes that need one, two and three pulses land well inside the limit. Setup, strobe and hold counts of 2, 3 and 1 give every strobe phase a different length, so a miscounted phase shifts the bus pattern that the model predicts.

// File: rtl/pgm_seq_pkg.sv
package pgm_seq_pkg;
   localparam logic [7:0] CMD_PROG  = 8'h40;
   localparam logic [7:0] CMD_CHECK = 8'hC0;
   localparam logic [7:0] CMD_READ  = 8'h00;

   typedef enum logic [1:0] {
      PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD
   } bus_phase_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CMD, ST_DATA, ST_PULSE, ST_VCMD, ST_SETTLE, ST_READ, ST_EXIT
   } seq_step_e;
endpackage

// File: rtl/pgm_us_timer.sv
module pgm_us_timer #(
   parameter int CLK_PER_US = 125,
   parameter int UW         = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [UW-1:0] n_us_i,
   output logic          fire_o
);
   logic          run_q;
   logic [UW-1:0] us_q, n_q;
   logic          us_end;

   generate
      if (CLK_PER_US == 1) begin : g_direct
         assign us_end = run_q;
      end else begin : g_presc
         localparam int PW = $clog2(CLK_PER_US);
         logic [PW-1:0] pre_q;
         assign us_end = run_q && (pre_q == PW'(CLK_PER_US - 1));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 pre_q <= '0;
            else if (start_i || us_end) pre_q <= '0;
            else if (run_q)             pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   assign fire_o = us_end && (us_q == n_q - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         us_q  <= '0;
         n_q   <= '0;
      end else if (start_i) begin
         run_q <= 1'b1;
         us_q  <= '0;
         n_q   <= n_us_i;
      end else if (fire_o) begin
         run_q <= 1'b0;
      end else if (us_end) begin
         us_q  <= us_q + 1'b1;
      end
   end
endmodule

// File: rtl/pgm_bus_engine.sv
module pgm_bus_engine
   import pgm_seq_pkg::*;
#(
   parameter int AW         = 17,
   parameter int SETUP_CYC  = 2,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go_i,
   input  logic          rd_i,
   input  logic [AW-1:0] addr_i,
   input  logic [7:0]    data_i,
   output logic [AW-1:0] addr_o,
   output logic [7:0]    data_o,
   output logic          ce_n_o,
   output logic          oe_n_o,
   output logic          we_n_o,
   output logic          done_o
);
   localparam int MAXC = (SETUP_CYC > STROBE_CYC) ?
                         ((SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC) :
                         ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC);
   localparam int CW = $clog2(MAXC + 1);

   bus_phase_e    ph_q;
   logic [CW-1:0] cnt_q;
   logic          rd_q;

   assign done_o = (ph_q == PH_HOLD) && (cnt_q == CW'(HOLD_CYC - 1));
   assign ce_n_o = (ph_q == PH_IDLE);
   assign we_n_o = !((ph_q == PH_STROBE) && !rd_q);
   assign oe_n_o = !(rd_q && (ph_q != PH_IDLE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q   <= PH_IDLE;
         cnt_q  <= '0;
         rd_q   <= 1'b0;
         addr_o <= '0;
         data_o <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (go_i) begin
               ph_q   <= PH_SETUP;
               cnt_q  <= '0;
               rd_q   <= rd_i;
               addr_o <= addr_i;
               data_o <= data_i;
            end
            PH_SETUP:
               if (cnt_q == CW'(SETUP_CYC - 1)) begin
                  ph_q <= PH_STROBE; cnt_q <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            PH_STROBE:
               if (cnt_q == CW'(STROBE_CYC - 1)) begin
                  ph_q <= PH_HOLD; cnt_q <= '0;
               end else cnt_q <= cnt_q + 1'b1;
            PH_HOLD:
               if (done_o) begin
                  ph_q <= PH_IDLE; cnt_q <= '0; rd_q <= 1'b0;
               end else cnt_q <= cnt_q + 1'b1;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/pgm_retry_seq.sv
module pgm_retry_seq
   import pgm_seq_pkg::*;
#(
   parameter int AW         = 17,
   parameter int LW         = 17,
   parameter int CLK_PER_US = 125,
   parameter int PULSE_US   = 10,
   parameter int VERIFY_US  = 6,
   parameter int MAX_TRIES  = 25,
   parameter int SETUP_CYC  = 2,
   parameter int STROBE_CYC = 3,
   parameter int HOLD_CYC   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [AW-1:0] base_addr_i,
   input  logic [LW-1:0] len_i,
   output logic [LW-1:0] src_idx_o,
   input  logic [7:0]    src_data_i,
   output logic [AW-1:0] fl_addr_o,
   output logic [7:0]    fl_wdata_o,
   input  logic [7:0]    fl_rdata_i,
   output logic          fl_ce_n_o,
   output logic          fl_oe_n_o,
   output logic          fl_we_n_o,
   output logic          done_o,
   output logic          fail_o
);
   localparam int UMAX = (PULSE_US > VERIFY_US) ? PULSE_US : VERIFY_US;
   localparam int UW   = $clog2(UMAX + 1);
   localparam int TW   = $clog2(MAX_TRIES + 1);

   if (SETUP_CYC < 1 || STROBE_CYC < 1 || HOLD_CYC < 1) begin : g_bad_strobe
      $error("strobe phase counts must be at least 1");
   end
   if (CLK_PER_US < 1 || PULSE_US < 1 || VERIFY_US < 1) begin : g_bad_time
      $error("timing parameters must be at least 1");
   end
   if (MAX_TRIES < 1 || AW < 1 || LW < 1) begin : g_bad_size
      $error("sizes and attempt limit must be at least 1");
   end

   seq_step_e     step_q;
   logic          launched_q;
   logic [AW-1:0] base_q;
   logic [LW-1:0] len_q, idx_q;
   logic [TW-1:0] tries_q;
   logic          fail_pend_q;

   logic          bus_step, tmr_step, go, tgo, bus_done, t_fire, advance;
   logic [7:0]    wbyte;
   logic [UW-1:0] n_us;

   assign bus_step = (step_q == ST_CMD) || (step_q == ST_DATA) || (step_q == ST_VCMD) ||
                     (step_q == ST_READ) || (step_q == ST_EXIT);
   assign tmr_step = (step_q == ST_PULSE) || (step_q == ST_SETTLE);
   assign go       = bus_step && !launched_q;
   assign tgo      = tmr_step && !launched_q;
   assign advance  = (bus_step && bus_done) || (tmr_step && t_fire);
   assign n_us     = (step_q == ST_PULSE) ? UW'(PULSE_US) : UW'(VERIFY_US);
   assign src_idx_o = idx_q;

   always_comb begin
      unique case (step_q)
         ST_CMD:  wbyte = CMD_PROG;
         ST_DATA: wbyte = src_data_i;
         ST_VCMD: wbyte = CMD_CHECK;
         default: wbyte = CMD_READ;
      endcase
   end

   pgm_bus_engine #(
      .AW(AW), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
   ) u_bus (
      .clk(clk), .rst_n(rst_n), .go_i(go), .rd_i(step_q == ST_READ),
      .addr_i(base_q + AW'(idx_q)), .data_i(wbyte),
      .addr_o(fl_addr_o), .data_o(fl_wdata_o),
      .ce_n_o(fl_ce_n_o), .oe_n_o(fl_oe_n_o), .we_n_o(fl_we_n_o), .done_o(bus_done)
   );

   pgm_us_timer #(.CLK_PER_US(CLK_PER_US), .UW(UW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start_i(tgo), .n_us_i(n_us), .fire_o(t_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q      <= ST_IDLE;
         launched_q  <= 1'b0;
         base_q      <= '0;
         len_q       <= '0;
         idx_q       <= '0;
         tries_q     <= '0;
         fail_pend_q <= 1'b0;
         done_o      <= 1'b0;
         fail_o      <= 1'b0;
      end else if (step_q == ST_IDLE) begin
         if (start_i) begin
            base_q      <= base_addr_i;
            len_q       <= len_i;
            idx_q       <= '0;
            tries_q     <= TW'(1);
            fail_pend_q <= 1'b0;
            done_o      <= 1'b0;
            fail_o      <= 1'b0;
            step_q      <= (len_i == '0) ? ST_EXIT : ST_CMD;
         end
      end else if (advance) begin
         launched_q <= 1'b0;
         unique case (step_q)
            ST_CMD:    step_q <= ST_DATA;
            ST_DATA:   step_q <= ST_PULSE;
            ST_PULSE:  step_q <= ST_VCMD;
            ST_VCMD:   step_q <= ST_SETTLE;
            ST_SETTLE: step_q <= ST_READ;
            ST_READ:
               if (fl_rdata_i == src_data_i) begin
                  tries_q <= TW'(1);
                  if (idx_q == len_q - 1'b1) step_q <= ST_EXIT;
                  else begin
                     idx_q  <= idx_q + 1'b1;
                     step_q <= ST_CMD;
                  end
               end else if (tries_q == TW'(MAX_TRIES)) begin
                  fail_pend_q <= 1'b1;
                  step_q      <= ST_EXIT;
               end else begin
                  tries_q <= tries_q + 1'b1;
                  step_q  <= ST_CMD;
               end
            ST_EXIT: begin
               done_o <= 1'b1;
               fail_o <= fail_pend_q;
               step_q <= ST_IDLE;
            end
            default: step_q <= ST_IDLE;
         endcase
      end else if (go || tgo) begin
         launched_q <= 1'b1;
      end
   end
endmodule

// File: rtl/pgm_retry_seq_chk.sv
module pgm_retry_seq_chk #(
   parameter int STROBE_CYC = 3
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic fl_ce_n_o,
   input logic fl_oe_n_o,
   input logic fl_we_n_o,
   input logic done_o,
   input logic fail_o
);
   int unsigned low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          low_cnt <= 0;
      else if (!fl_we_n_o) low_cnt <= low_cnt + 1;
      else                 low_cnt <= 0;
   end

   assert_we_in_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n_o |-> !fl_ce_n_o);

   assert_strobe_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n_o) |-> (low_cnt == STROBE_CYC));

   assert_no_read_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(!fl_we_n_o && !fl_oe_n_o));

   assert_fail_has_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> done_o);

   assert_bus_quiet_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> fl_ce_n_o);

   assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> done_o);
endmodule

bind pgm_retry_seq pgm_retry_seq_chk #(.STROBE_CYC(STROBE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i),
   .fl_ce_n_o(fl_ce_n_o), .fl_oe_n_o(fl_oe_n_o), .fl_we_n_o(fl_we_n_o),
   .done_o(done_o), .fail_o(fail_o)
);

// File: tb/pgm_retry_seq_tb.sv
`timescale 1ns/1ps
module pgm_retry_seq_tb;
   localparam int AW = 8, LW = 4, CPU = 3, PUS = 10, VUS = 6, MAXT = 4;
   localparam int SC = 2, LC = 3, HC = 1, T = SC + LC + HC;

   logic clk = 0, rst_n = 0, start = 0;
   logic [AW-1:0] base = 0;
   logic [LW-1:0] len = 0, src_idx;
   logic [7:0] src_data, wdata, rdata;
   logic [AW-1:0] addr;
   logic ce_n, oe_n, we_n, done, fail;

   pgm_retry_seq #(.AW(AW), .LW(LW), .CLK_PER_US(CPU), .PULSE_US(PUS), .VERIFY_US(VUS),
      .MAX_TRIES(MAXT), .SETUP_CYC(SC), .STROBE_CYC(LC), .HOLD_CYC(HC)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base), .len_i(len),
      .src_idx_o(src_idx), .src_data_i(src_data), .fl_addr_o(addr), .fl_wdata_o(wdata),
      .fl_rdata_i(rdata), .fl_ce_n_o(ce_n), .fl_oe_n_o(oe_n), .fl_we_n_o(we_n),
      .done_o(done), .fail_o(fail));

   always #4 clk = ~clk;

   int checks = 0, errs = 0;
   logic [7:0] bufm [16];
   int need [16];
   int pcnt [16];
   logic [7:0] pdat [16];
   int nwr = 0;
   logic [7:0] lastcmd = 8'hFF;
   logic armed = 0, prev_we = 1;

   assign src_data = bufm[src_idx];

   // flash stand-in: cell reads right once it has had enough pulses
   always_comb begin
      automatic int ix = int'(addr - base) & 15;
      rdata = (pcnt[ix] >= need[ix]) ? bufm[ix] : (bufm[ix] ^ 8'h5A);
   end

   always @(posedge clk) begin
      if (rst_n && !prev_we && we_n) begin
         automatic int ix = int'(addr - base) & 15;
         nwr++;
         if (armed) begin
            pcnt[ix]++; pdat[ix] = wdata; armed = 0;
         end else begin
            lastcmd = wdata; armed = (wdata == 8'h40);
         end
      end
      prev_we <= we_n;
   end

   // reference expectations, updated just after each edge
   logic e_ce = 1, e_oe = 1, e_we = 1, e_done = 0, e_fail = 0, cmp_en = 0;
   logic [AW-1:0] e_addr = 0;
   logic [7:0] e_wd = 0;
   string req = "R1";

   always @(negedge clk) if (cmp_en) begin
      checks++;
      if (ce_n !== e_ce || oe_n !== e_oe || we_n !== e_we || done !== e_done ||
          fail !== e_fail || (!e_ce && addr !== e_addr) || (!e_we && wdata !== e_wd)) begin
         errs++;
         $display("FAIL %s t=%0t act ce%b oe%b we%b a%h d%h dn%b fl%b exp ce%b oe%b we%b a%h d%h dn%b fl%b",
            req, $time, ce_n, oe_n, we_n, addr, wdata, done, fail,
            e_ce, e_oe, e_we, e_addr, e_wd, e_done, e_fail);
      end
   end

   task automatic chk(input string r, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errs++;
         $display("FAIL %s actual %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk); #1;
   endtask

   task automatic bus_op(input logic [AW-1:0] a, input logic [7:0] d, input bit rd, input string r);
      for (int p = 0; p < T; p++) begin
         cyc(); req = r;
         e_ce = 0; e_oe = !rd; e_we = !(!rd && p >= SC && p < SC + LC);
         e_addr = a; e_wd = d;
      end
      cyc(); e_ce = 1; e_oe = 1; e_we = 1;
   endtask

   task automatic idle_for(input int n, input string r);
      for (int i = 0; i < n; i++) begin cyc(); req = r; end
   endtask

   task automatic prep(input int n);
      for (int i = 0; i < 16; i++) begin
         pcnt[i] = 0; pdat[i] = 0; bufm[i] = 8'(i * 37 + 11); need[i] = 1;
      end
      nwr = 0; armed = 0;
   endtask

   task automatic run(input logic [AW-1:0] b, input int n);
      bit fl = 0;
      int last = 0;
      base = b; len = LW'(n);
      @(negedge clk); start = 1;
      cyc(); start = 0; req = "R10"; e_done = 0; e_fail = 0;
      for (int i = 0; i < n && !fl; i++) begin
         int k = 1;
         last = i;
         forever begin
            bus_op(b + AW'(i), 8'h40, 0, (k == 1) ? "R6" : "R7");
            bus_op(b + AW'(i), bufm[i], 0, "R2");
            idle_for(PUS * CPU + 1, "R4");
            bus_op(b + AW'(i), 8'hC0, 0, "R4");
            idle_for(VUS * CPU + 1, "R5");
            bus_op(b + AW'(i), 8'h00, 1, "R5");
            if (k >= need[i]) break;
            if (k == MAXT) begin fl = 1; break; end
            k++;
         end
      end
      bus_op(b + AW'(last), 8'h00, 0, fl ? "R8" : ((n == 0) ? "R12" : "R9"));
      e_done = 1; e_fail = fl;
      req = fl ? "R8" : "R9";
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         errs++; checks++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
         $finish;
      end
   end

   initial begin
      prep(0);
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 ce_n", ce_n, 1); chk("R1 we_n", we_n, 1); chk("R1 oe_n", oe_n, 1);
      chk("R1 done", done, 0); chk("R1 fail", fail, 0);
      @(negedge clk); rst_n = 1; cmp_en = 1;
      idle_for(4, "R1");

      // pass run with retries, plus a start during the run (R11)
      prep(3); need[0] = 1; need[1] = 3; need[2] = 2;
      fork
         run(8'h20, 3);
         begin
            repeat (150) @(negedge clk);
            start = 1; @(negedge clk); start = 0;
         end
      join
      chk("R6 byte0 pulses", pcnt[0], 1);
      chk("R7 byte1 pulses", pcnt[1], 3);
      chk("R6 byte2 pulses restart", pcnt[2], 2);
      chk("R2 byte1 data", pdat[1], bufm[1]);
      chk("R9 final command", lastcmd, 0);
      chk("R11 done after stray start", done, 1);
      idle_for(20, "R10");
      chk("R10 done held", done, 1);

      // fail run: byte1 never verifies
      prep(2); need[1] = 9;
      run(8'h50, 2);
      chk("R8 pulses at limit", pcnt[1], MAXT);
      chk("R6 byte0 pulses", pcnt[0], 1);
      chk("R8 fail flag", fail, 1);
      idle_for(10, "R10");
      chk("R10 fail held", fail, 1);

      // zero-length run
      prep(0);
      run(8'h70, 0);
      chk("R12 write count", nwr, 1);
      chk("R12 command", lastcmd, 0);
      chk("R12 fail low", fail, 0);
      idle_for(5, "R10");

      cmp_en = 0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
      $finish;
   end
endmodule